// File: doc/BRIEF.md
# Port Pin Function Multiplexer

This block sits between the control state of an eight-pin general-purpose port and its pads. For each pin it decides, by a fixed priority, whether a general-purpose output or an on-chip peripheral drives the pad and whether the pad driver is on. Four low pins can be taken over by PWM channels. Pin 1 can also carry a doubled bus clock. Pin 0 can also carry a periodic-interrupt clock when that clock is steered to it. Which of these alternate functions exist is set at elaboration by a package-variant parameter.

Pins 3 to 0 also feed the analog converter's external trigger inputs with the level seen at the pad. Every pin has a change detector on its synchronized pad level. An edge of the chosen polarity sets a per-pin flag, and the flag is cleared by writing one to it. The block combines the enabled flags into a single interrupt request. The register bus that holds the enable, polarity and clear bits is outside the block, so these bits are plain ports.

Top module: `port_pin_mux`

## Requirements
- R1: After reset every pin flag is 0 and `irq` is 0.
- R2: On a pin where no alternate function is active, `pad_oe` equals `gp_dir` and `pad_out` equals `gp_data`. This holds on all eight pins.
- R3: When `pwm_en[k]` is 1 on pin 3 or pin 2 (variants other than small), `pad_oe[k]` is 1 and `pad_out[k]` equals `pwm_out[k]`.
- R4: On pin 1 in the full variant, the priority is `pwm_en[1]`, then `dclk_en`, then general-purpose output. Either enabled alternate function forces `pad_oe[1]` to 1 and drives its own value.
- R5: On pin 0 in the full variant, the priority is `pwm_en[0]`, then the periodic clock, then general-purpose output. The periodic clock takes the pin only when `pclk_en` and `pclk_route` are both 1, and it then forces `pad_oe[0]` to 1 with `pad_out[0]` = `pclk_out`.
- R6: In the mid variant (VARIANT = PKG_MID, encoding 1), `dclk_en`, `pclk_en` and `pclk_route` have no effect. Pins 1 and 0 fall back to PWM over general-purpose output.
- R7: In the small variant (VARIANT = PKG_SMALL, encoding 2), the PWM and clock enables have no effect. `trig_out` stays 0, no flag is ever set, and `irq` stays 0.
- R8: For k in 3..0, `trig_out[k]` = `pad_in[k]` AND `trig_en[k]`. `trig_en` never changes `pad_out` or `pad_oe`.
- R9: `pin_irq_pol[i]` = 0 selects falling edges and 1 selects rising edges. A selected edge on `pad_in[i]` sets `pin_irq_flag[i]` on the third rising clock edge after the change. The opposite edge does not set the flag, and the pin direction does not matter.
- R10: A 1 on `pin_irq_clr[i]` for one cycle clears `pin_irq_flag[i]` at the next clock edge. If an edge is detected in the same cycle, the set wins.
- R11: `irq` is the OR over all pins of `pin_irq_flag` AND `pin_irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gp_data | input | NPINS | General-purpose output data per pin |
| gp_dir | input | NPINS | General-purpose direction, 1 = output |
| pwm_en | input | NPWM | PWM channel enable for pins NPWM-1..0 |
| pwm_out | input | NPWM | PWM channel output value |
| dclk_en | input | 1 | Doubled bus clock output enable (pin 1) |
| dclk_out | input | 1 | Doubled bus clock value |
| pclk_en | input | 1 | Periodic-interrupt clock enable |
| pclk_route | input | 1 | Periodic-interrupt clock steered to pin 0 |
| pclk_out | input | 1 | Periodic-interrupt clock value |
| trig_en | input | NTRIG | Converter trigger tap enable per low pin |
| pad_in | input | NPINS | Pad input level |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| trig_out | output | NTRIG | Converter external triggers |
| pin_irq_en | input | NPINS | Pin interrupt enable |
| pin_irq_pol | input | NPINS | Edge polarity, 0 falling, 1 rising |
| pin_irq_clr | input | NPINS | Write-one-to-clear strobe for flags |
| pin_irq_flag | output | NPINS | Pin interrupt flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The output path is tried with one pattern for each priority level. First only the general-purpose bits are set. Then the doubled clock or the periodic clock is set alone, and then the same clock together with a PWM enable, with data values chosen so that each winner drives a different level. The periodic clock is also tried enabled but not routed, which shows that both conditions are required. The same inputs go to full, mid and small instances side by side, which separates the variants by which enables they honour. Edges are driven in both directions against both polarities, with the pin set as output as well as input, to show the polarity selection and that direction does not matter. A clear strobe placed on the very cycle a new edge lands shows whether set wins over clear.

// File: rtl/ppm_pkg.sv
// Shared types for the port pin multiplexer.
// Assumes: package variants are fixed at elaboration time.
package ppm_pkg;
    typedef enum logic [1:0] {
        PKG_FULL  = 2'd0,
        PKG_MID   = 2'd1,
        PKG_SMALL = 2'd2
    } pkg_variant_e;

    localparam int SYNC_STAGES = 2;
    localparam int WARMUP_CYC  = SYNC_STAGES + 1;
endpackage

// File: rtl/ppm_sync.sv
// Pad level synchronizer: a chain of flops per bit into the clk domain.
// Assumes: each bit is an independent asynchronous level.
module ppm_sync #(
    parameter int W      = 8,
    parameter int STAGES = ppm_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Shift the pad level through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ppm_edge_flag.sv
// Per-pin edge detector and sticky flag with write-one-to-clear.
// Assumes: lvl is already synchronized. Edges seen before the
// synchronizer has filled after reset are ignored.
module ppm_edge_flag #(
    parameter int W      = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flag
);
    localparam int CW = $clog2(ppm_pkg::WARMUP_CYC + 1);

    logic [W-1:0]  lvl_prev;
    logic [W-1:0]  rise, fall, hit;
    logic [CW-1:0] warm_cnt;
    logic          armed;

    // Count cycles after reset until the level history is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_cnt <= '0;
        else if (!armed)
            warm_cnt <= warm_cnt + 1'b1;
    end

    assign armed = (warm_cnt == CW'(ppm_pkg::WARMUP_CYC));

    // Keep the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= '0;
        else        lvl_prev <= lvl;
    end

    // Select the edge per pin: polarity 1 rising, 0 falling.
    always_comb begin
        rise = lvl & ~lvl_prev;
        fall = ~lvl & lvl_prev;
        hit  = (ENABLE && armed) ? ((pol & rise) | (~pol & fall)) : '0;
    end

    // Sticky flag: a detected edge outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= '0;
        else        flag <= (flag & ~clr) | hit;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> flag[i]); // R10
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !hit[i]) |=> !flag[i]); // R10
        AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> $past(lvl[i]) != $past(lvl_prev[i])); // R9
    end
endmodule

// File: rtl/ppm_out_mux.sv
// Per-pin output priority: PWM, then the pin's clock output, then the
// general-purpose registers. Alternate enables arrive already masked by
// the package variant, so this module does not depend on the variant.
// Assumes: NPWM >= 2 so that pins 1 and 0 carry PWM channels.
module ppm_out_mux #(
    parameter int NPINS = 8,
    parameter int NPWM  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] gp_data,
    input  logic [NPINS-1:0] gp_dir,
    input  logic [NPWM-1:0]  pwm_act,
    input  logic [NPWM-1:0]  pwm_out,
    input  logic             dclk_act,
    input  logic             dclk_out,
    input  logic             pclk_act,
    input  logic             pclk_out,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        if (p < NPWM) begin : g_alt
            logic alt_on, alt_val;
            if (p == 1) begin : g_dclk
                // PWM1 outranks the doubled clock.
                assign alt_on  = pwm_act[p] | dclk_act;
                assign alt_val = pwm_act[p] ? pwm_out[p] : dclk_out;
                AST_DCLK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
                    (!pwm_act[p] && dclk_act) |-> (pad_oe[p] && pad_out[p] == dclk_out)); // R4
            end else if (p == 0) begin : g_pclk
                // PWM0 outranks the periodic clock.
                assign alt_on  = pwm_act[p] | pclk_act;
                assign alt_val = pwm_act[p] ? pwm_out[p] : pclk_out;
                AST_PCLK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
                    (!pwm_act[p] && pclk_act) |-> (pad_oe[p] && pad_out[p] == pclk_out)); // R5
            end else begin : g_pwm_only
                assign alt_on  = pwm_act[p];
                assign alt_val = pwm_out[p];
            end
            // Any active alternate function forces the pad to drive.
            assign pad_oe[p]  = alt_on | gp_dir[p];
            assign pad_out[p] = alt_on ? alt_val : gp_data[p];

            AST_PWM_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
                pwm_act[p] |-> (pad_oe[p] && pad_out[p] == pwm_out[p])); // R3
        end else begin : g_gpo
            // Plain general-purpose pin.
            assign pad_oe[p]  = gp_dir[p];
            assign pad_out[p] = gp_data[p];
        end
    end
endmodule

// File: rtl/port_pin_mux.sv
// Top of the port pin multiplexer. It masks the alternate function
// enables by package variant, drives the pads and converter triggers, and
// gathers the pin-change flags into one interrupt request.
// Assumes: control bits come from an external register file; the clear
// strobe is high for one cycle per write.
module port_pin_mux #(
    parameter int                    NPINS   = 8,
    parameter int                    NPWM    = 4,
    parameter int                    NTRIG   = 4,
    parameter ppm_pkg::pkg_variant_e VARIANT = ppm_pkg::PKG_FULL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] gp_data,
    input  logic [NPINS-1:0] gp_dir,
    input  logic [NPWM-1:0]  pwm_en,
    input  logic [NPWM-1:0]  pwm_out,
    input  logic             dclk_en,
    input  logic             dclk_out,
    input  logic             pclk_en,
    input  logic             pclk_route,
    input  logic             pclk_out,
    input  logic [NTRIG-1:0] trig_en,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NTRIG-1:0] trig_out,
    input  logic [NPINS-1:0] pin_irq_en,
    input  logic [NPINS-1:0] pin_irq_pol,
    input  logic [NPINS-1:0] pin_irq_clr,
    output logic [NPINS-1:0] pin_irq_flag,
    output logic             irq
);
    import ppm_pkg::*;

    localparam bit HAS_ALT  = (VARIANT != PKG_SMALL);
    localparam bit HAS_CLKS = (VARIANT == PKG_FULL);

    logic [NPWM-1:0]  pwm_act;
    logic             dclk_act, pclk_act;
    logic [NPINS-1:0] pad_sync;

    // Mask alternate enables with what the package variant provides.
    always_comb begin
        pwm_act  = HAS_ALT  ? pwm_en : '0;
        dclk_act = HAS_CLKS ? dclk_en : 1'b0;
        pclk_act = HAS_CLKS ? (pclk_en & pclk_route) : 1'b0;
    end

    ppm_out_mux #(.NPINS(NPINS), .NPWM(NPWM)) u_out_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .gp_data  (gp_data),
        .gp_dir   (gp_dir),
        .pwm_act  (pwm_act),
        .pwm_out  (pwm_out),
        .dclk_act (dclk_act),
        .dclk_out (dclk_out),
        .pclk_act (pclk_act),
        .pclk_out (pclk_out),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    // Trigger taps observe the raw pad level and never touch direction.
    assign trig_out = HAS_ALT ? (pad_in[NTRIG-1:0] & trig_en) : '0;

    ppm_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    ppm_edge_flag #(.W(NPINS), .ENABLE(HAS_ALT)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pad_sync),
        .pol   (pin_irq_pol),
        .clr   (pin_irq_clr),
        .flag  (pin_irq_flag)
    );

    // Combine the enabled flags into one request.
    assign irq = |(pin_irq_flag & pin_irq_en);

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pin_irq_flag != '0)); // R11
    AST_TRIG_FOLLOWS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out & ~pad_in[NTRIG-1:0]) == '0); // R8
    AST_SMALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_ALT |-> (pin_irq_flag == '0 && !irq)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pin_irq_flag == '0)); // R1
endmodule

// File: tb/test_port_pin_mux.sv
module test_port_pin_mux;
    import ppm_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [7:0] gp_data = '0, gp_dir = '0, pad_in = '0;
    logic [3:0] pwm_en = '0, pwm_out = '0, trig_en = '0;
    logic dclk_en = 0, dclk_out = 0, pclk_en = 0, pclk_route = 0, pclk_out = 0;
    logic [7:0] irq_en = '0, irq_pol = '0, irq_clr = '0;

    logic [7:0] f_out, f_oe, f_flag, m_out, m_oe, m_flag, s_out, s_oe, s_flag;
    logic [3:0] f_trig, m_trig, s_trig;
    logic f_irq, m_irq, s_irq;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    port_pin_mux #(.VARIANT(PKG_FULL)) i_port_pin_mux (
        .clk(clk), .rst_n(rst_n), .gp_data(gp_data), .gp_dir(gp_dir),
        .pwm_en(pwm_en), .pwm_out(pwm_out), .dclk_en(dclk_en), .dclk_out(dclk_out),
        .pclk_en(pclk_en), .pclk_route(pclk_route), .pclk_out(pclk_out),
        .trig_en(trig_en), .pad_in(pad_in), .pad_out(f_out), .pad_oe(f_oe),
        .trig_out(f_trig), .pin_irq_en(irq_en), .pin_irq_pol(irq_pol),
        .pin_irq_clr(irq_clr), .pin_irq_flag(f_flag), .irq(f_irq));

    port_pin_mux #(.VARIANT(PKG_MID)) i_port_pin_mux_mid (
        .clk(clk), .rst_n(rst_n), .gp_data(gp_data), .gp_dir(gp_dir),
        .pwm_en(pwm_en), .pwm_out(pwm_out), .dclk_en(dclk_en), .dclk_out(dclk_out),
        .pclk_en(pclk_en), .pclk_route(pclk_route), .pclk_out(pclk_out),
        .trig_en(trig_en), .pad_in(pad_in), .pad_out(m_out), .pad_oe(m_oe),
        .trig_out(m_trig), .pin_irq_en(irq_en), .pin_irq_pol(irq_pol),
        .pin_irq_clr(irq_clr), .pin_irq_flag(m_flag), .irq(m_irq));

    port_pin_mux #(.VARIANT(PKG_SMALL)) i_port_pin_mux_small (
        .clk(clk), .rst_n(rst_n), .gp_data(gp_data), .gp_dir(gp_dir),
        .pwm_en(pwm_en), .pwm_out(pwm_out), .dclk_en(dclk_en), .dclk_out(dclk_out),
        .pclk_en(pclk_en), .pclk_route(pclk_route), .pclk_out(pclk_out),
        .trig_en(trig_en), .pad_in(pad_in), .pad_out(s_out), .pad_oe(s_oe),
        .trig_out(s_trig), .pin_irq_en(irq_en), .pin_irq_pol(irq_pol),
        .pin_irq_clr(irq_clr), .pin_irq_flag(s_flag), .irq(s_irq));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Settle after a drive made at a falling edge.
    task automatic settle();
        #1;
    endtask

    // Wait until a pad change made at a falling edge reaches the flag.
    task automatic wait_flag();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 full flags", f_flag, 0);
        check("R1 full irq", f_irq, 0);
        check("R1 mid flags", m_flag, 0);
    endtask

    task automatic t_gpo();
        @(negedge clk);
        gp_data = 8'hA5; gp_dir = 8'h3C; settle();
        check("R2 oe", f_oe, 8'h3C);
        check("R2 out", f_out, 8'hA5);
        gp_data = 8'h5A; gp_dir = 8'hC3; settle();
        check("R2 oe alt pattern", f_oe, 8'hC3);
        check("R2 out alt pattern", f_out, 8'h5A);
    endtask

    task automatic t_pwm_hi();
        @(negedge clk);
        gp_data = 8'h00; gp_dir = 8'h00;
        pwm_en = 4'b1100; pwm_out = 4'b0100; settle();
        check("R3 oe pins 3,2", f_oe[3:2], 2'b11);
        check("R3 out pins 3,2", f_out[3:2], 2'b01);
        check("R3 mid oe pins 3,2", m_oe[3:2], 2'b11);
        check("R7 small ignores pwm", s_oe[3:2], 2'b00);
        pwm_en = 0; pwm_out = 0;
    endtask

    task automatic t_pin1();
        @(negedge clk);
        gp_data = 8'h00; gp_dir = 8'h00;
        dclk_en = 1; dclk_out = 1; settle();
        check("R4 dclk forces oe", f_oe[1], 1);
        check("R4 dclk value", f_out[1], 1);
        check("R6 mid ignores dclk", m_oe[1], 0);
        pwm_en[1] = 1; pwm_out[1] = 0; settle();
        check("R4 pwm1 wins value", f_out[1], 0);
        check("R4 pwm1 oe", f_oe[1], 1);
        check("R6 mid pwm1 oe", m_oe[1], 1);
        dclk_en = 0; dclk_out = 0; pwm_en = 0; pwm_out = 0;
    endtask

    task automatic t_pin0();
        @(negedge clk);
        gp_data = 8'h01; gp_dir = 8'h00;
        pclk_en = 1; pclk_route = 0; pclk_out = 0; settle();
        check("R5 not routed keeps gpo oe", f_oe[0], 0);
        pclk_route = 1; settle();
        check("R5 routed forces oe", f_oe[0], 1);
        check("R5 routed value", f_out[0], 0);
        check("R6 mid ignores pclk", m_oe[0], 0);
        pwm_en[0] = 1; pwm_out[0] = 1; settle();
        check("R5 pwm0 wins value", f_out[0], 1);
        pclk_en = 0; pclk_route = 0; pwm_en = 0; pwm_out = 0;
        gp_data = 0;
        settle();
        check("R7 small pin0 gpo", s_oe[0], 0);
    endtask

    task automatic t_trig();
        @(negedge clk);
        gp_data = 8'h0F; gp_dir = 8'h05; pad_in = 8'h0A;
        trig_en = 4'b0000; settle();
        check("R8 trig off", f_trig, 4'b0000);
        trig_en = 4'b0110; settle();
        check("R8 trig gated", f_trig, 4'b0010);
        check("R8 trig leaves oe", f_oe, 8'h05);
        check("R8 trig leaves out", f_out, 8'h0F);
        trig_en = 4'b1111; settle();
        check("R8 trig all", f_trig, 4'b1010);
        check("R7 small trig zero", s_trig, 4'b0000);
        trig_en = 0; gp_data = 0; gp_dir = 0;
        pad_in = 0;
        wait_flag(); wait_flag();
        irq_clr = 8'hFF; @(negedge clk); irq_clr = 0;
    endtask

    task automatic t_edges();
        @(negedge clk);
        irq_pol = 8'b0100_0000;  // pin 5 falling, pin 6 rising
        gp_dir[6] = 1;           // pin 6 configured as output
        pad_in[5] = 1;
        wait_flag();
        check("R9 rising ignored on falling pin", f_flag[5], 0);
        pad_in[5] = 0;
        wait_flag();
        check("R9 falling sets", f_flag[5], 1);
        pad_in[6] = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 not yet after two edges", f_flag[6], 0);
        @(posedge clk); @(negedge clk);
        check("R9 rising sets on output pin", f_flag[6], 1);
        check("R7 small no flags", s_flag, 0);
        irq_clr = 8'b0110_0000;
        @(negedge clk);
        irq_clr = 0;
        check("R10 clear", f_flag, 0);
        pad_in[6] = 0; gp_dir[6] = 0;
        wait_flag();
        check("R9 falling ignored on rising pin", f_flag[6], 0);
    endtask

    task automatic t_set_wins();
        @(negedge clk);
        irq_pol[2] = 1;
        pad_in[2] = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        irq_clr[2] = 1;          // lands on the edge that sets the flag
        @(negedge clk);
        irq_clr[2] = 0;
        check("R10 set wins over clear", f_flag[2], 1);
    endtask

    task automatic t_irq();
        @(negedge clk);
        irq_en = 8'h00; settle();
        check("R11 disabled", f_irq, 0);
        irq_en = 8'hFB; settle();
        check("R11 other pins enabled", f_irq, 0);
        irq_en = 8'h04; settle();
        check("R11 enabled pin", f_irq, 1);
        irq_en = 8'hFF; settle();
        check("R7 small irq", s_irq, 0);
        irq_clr = 8'h04; @(negedge clk); irq_clr = 0;
        check("R11 drops after clear", f_irq, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        settle();
        check("R1 flags in reset", f_flag, 0);
        @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        t_reset();
        t_gpo();
        t_pwm_hi();
        t_pin1();
        t_pin0();
        t_trig();
        t_edges();
        t_set_wins();
        t_irq();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule